// File: doc/BRIEF.md
# UART Software Flow-Control Engine

This block performs in-band Xon/Xoff flow control for one UART channel. Every character the deserializer delivers passes through it on its way to the receive FIFO. Each character is compared against four programmable control characters: two "resume" values (on-A, on-B) and two "stop" values (off-A, off-B). A character recognised as flow control is consumed. A stop sets a transmit-pause state that blocks the host's next character from reaching the serializer. A resume clears that state.

On the transmit side, the block watches the receive FIFO occupancy. When the occupancy reaches a high threshold, it inserts a stop request, either as one character or as a two-character sequence. When the occupancy later drops to a low threshold, it inserts a resume request. Inserted characters take precedence over host data. Two sticky interrupt flags report stop reception and special-character matches. A 4-bit mode and a special-detect enable are held in the block and loaded through a write strobe. Reset clears both, so flow control starts fully off.

The deserializer delivers characters with at least one idle cycle between them, which matches any real line rate. The FIFO accepts whatever is forwarded. A first byte of a two-byte sequence that has not yet been resolved is held until the next character arrives.

Top module: `uart_swfc`

## Requirements
- R1: After reset the held mode is 0000 and special detect is off, `tx_pause`, `irq_xoff` and `irq_spc` are 0, and every received character is forwarded unchanged on `rx_out_*` one cycle after it is taken.
- R2: Mode bits [1:0] select the receive match. With 10 the pair on-A/off-A is matched, and with 01 the pair on-B/off-B. A matched stop is not forwarded and sets `tx_pause` and `irq_xoff`. A matched resume is not forwarded and clears `tx_pause`. Any other character is forwarded and leaves `tx_pause` unchanged.
- R3: With receive bits 11 and transmit bits [3:2] at 10 or 01, either on-A or on-B acts as a resume, and either off-A or off-B acts as a stop. Each is consumed.
- R4: With receive bits 11 and transmit bits 11 or 00, only on-A followed by on-B (resume) or off-A followed by off-B (stop) acts, and both bytes are consumed. If a held first byte is followed by anything else, the held byte is forwarded in the cycle the new character is taken. A new character that is not itself a first byte is forwarded one cycle later.
- R5: With special detect enabled, any received character equal to off-B sets `irq_spc`. With receive bits 10 that character is still forwarded. With receive bits 01 it is consumed and sets both `irq_xoff` and `irq_spc`. With detect disabled, `irq_spc` is not set.
- R6: While `tx_pause` is 1, host data is not accepted (`tx_data_ready` = 0) and is not presented to the serializer. A character already handed over is unaffected.
- R7: With transmit bits other than 00, occupancy reaching `cfg_hi_thr` inserts one stop request, and occupancy later falling to `cfg_lo_thr` inserts one resume request. Bits 10 send off-A or on-A. Bits 01 send off-B or on-B. Bits 11 send off-A then off-B, or on-A then on-B. Bits 00 send nothing.
- R8: While an inserted character is pending, it is presented on `tx_out_data` in place of host data, held stable until `tx_out_ready`, and `tx_data_ready` is 0.
- R9: `irq_xoff` and `irq_spc` stay set until a one-cycle `irq_clr`. A set event in the same cycle as `irq_clr` wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Load strobe for mode and special-detect enable |
| cfg_mode | input | 4 | Mode: [3:2] transmit select, [1:0] receive select |
| cfg_spc_en | input | 1 | Special-character detect enable |
| cfg_xon1 | input | 8 | Resume character A |
| cfg_xon2 | input | 8 | Resume character B |
| cfg_xoff1 | input | 8 | Stop character A |
| cfg_xoff2 | input | 8 | Stop character B, also the special character |
| cfg_hi_thr | input | OCC_W | Occupancy that triggers a stop request |
| cfg_lo_thr | input | OCC_W | Occupancy that triggers a resume request |
| rx_occ | input | OCC_W | Current receive FIFO occupancy |
| rx_in_valid | input | 1 | Received character strobe from the deserializer |
| rx_in_data | input | 8 | Received character |
| rx_out_valid | output | 1 | Character write to the receive FIFO |
| rx_out_data | output | 8 | Character forwarded to the FIFO |
| tx_data_valid | input | 1 | Host has a character to send |
| tx_data | input | 8 | Host character |
| tx_data_ready | output | 1 | Host character is taken this cycle |
| tx_out_valid | output | 1 | Character offered to the serializer |
| tx_out_data | output | 8 | Character offered to the serializer |
| tx_out_ready | input | 1 | Serializer takes the offered character |
| tx_pause | output | 1 | Transmit pause state set by a received stop |
| irq_xoff | output | 1 | Sticky stop-received flag |
| irq_spc | output | 1 | Sticky special-character flag |
| irq_clr | input | 1 | One-cycle clear of both flags |

## Verification
On every cycle, the assertions check the following:
- With matching off, a character appears at the FIFO port one cycle after it is taken.
- A recognised stop sets both the pause state and its flag.
- A broken two-byte sequence flushes the held byte.
- Inserted characters stay stable and lock out host data.
- A second inserted byte always follows a first.
- The flags are sticky.

Only the directed scenarios can show the following:
- Which byte values each mode recognises.
- That a held first byte is flushed in the right order.
- The forward-or-consume behaviour of the special character under each receive mode.
- The threshold hysteresis and the exact one- or two-byte insertion for each transmit mode.

// File: rtl/uart_swfc_pkg.sv
package uart_swfc_pkg;

    localparam int CHAR_W = 8;

    // Two-bit selector used for both directions
    typedef enum logic [1:0] {
        FC_NONE = 2'b00,
        FC_SETB = 2'b01,
        FC_SETA = 2'b10,
        FC_BOTH = 2'b11
    } fc_sel_e;

    typedef struct packed {
        fc_sel_e tx;   // bits [3:2]
        fc_sel_e rx;   // bits [1:0]
    } fc_mode_t;

    typedef struct packed {
        logic [CHAR_W-1:0] on_a;
        logic [CHAR_W-1:0] on_b;
        logic [CHAR_W-1:0] off_a;
        logic [CHAR_W-1:0] off_b;
    } fc_chars_t;

    typedef enum logic [1:0] {
        HOLD_NONE = 2'd0,
        HOLD_ON   = 2'd1,
        HOLD_OFF  = 2'd2
    } hold_e;

    typedef enum logic [1:0] {
        INS_IDLE   = 2'd0,
        INS_FIRST  = 2'd1,
        INS_SECOND = 2'd2
    } ins_e;

    // Receive side needs the two-byte sequence
    function automatic logic rx_needs_pair(fc_mode_t m);
        return (m.rx == FC_BOTH) && ((m.tx == FC_BOTH) || (m.tx == FC_NONE));
    endfunction

endpackage

// File: rtl/uart_swfc_rx.sv
module uart_swfc_rx
    import uart_swfc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  fc_mode_t          mode,
    input  logic              spc_en,
    input  fc_chars_t         chars,
    input  logic              in_valid,
    input  logic [CHAR_W-1:0] in_data,
    output logic              out_valid,
    output logic [CHAR_W-1:0] out_data,
    output logic              on_evt,
    output logic              off_evt,
    output logic              spc_evt
);

    logic              fwd_v;
    logic [CHAR_W-1:0] fwd_d;
    logic              spill_v, spill_v_n;
    logic [CHAR_W-1:0] spill_d, spill_d_n;
    hold_e             hold, hold_n;
    logic [CHAR_W-1:0] hold_d, hold_d_n;
    logic              is_on, is_off;

    // Single-byte classification for the non-sequence modes
    always_comb begin
        is_on  = 1'b0;
        is_off = 1'b0;
        unique case (mode.rx)
            FC_SETA: begin
                is_on  = (in_data == chars.on_a);
                is_off = (in_data == chars.off_a);
            end
            FC_SETB: begin
                is_on  = (in_data == chars.on_b);
                is_off = (in_data == chars.off_b);
            end
            FC_BOTH: begin
                is_on  = (in_data == chars.on_a)  || (in_data == chars.on_b);
                is_off = (in_data == chars.off_a) || (in_data == chars.off_b);
            end
            default: ;
        endcase
    end

    always_comb begin
        fwd_v     = 1'b0;
        fwd_d     = in_data;
        spill_v_n = 1'b0;
        spill_d_n = spill_d;
        hold_n    = hold;
        hold_d_n  = hold_d;
        on_evt    = 1'b0;
        off_evt   = 1'b0;
        spc_evt   = 1'b0;
        if (spill_v) begin
            fwd_v = 1'b1;
            fwd_d = spill_d;
        end
        if (!rx_needs_pair(mode)) begin
            hold_n = HOLD_NONE;
        end
        if (in_valid) begin
            spc_evt = spc_en && (in_data == chars.off_b);
            if (rx_needs_pair(mode)) begin
                if (hold == HOLD_ON && in_data == chars.on_b) begin
                    on_evt = 1'b1;
                    hold_n = HOLD_NONE;
                end else if (hold == HOLD_OFF && in_data == chars.off_b) begin
                    off_evt = 1'b1;
                    hold_n  = HOLD_NONE;
                end else begin
                    if (hold != HOLD_NONE) begin
                        fwd_v = 1'b1;
                        fwd_d = hold_d;
                    end
                    hold_n = HOLD_NONE;
                    if (in_data == chars.on_a) begin
                        hold_n   = HOLD_ON;
                        hold_d_n = in_data;
                    end else if (in_data == chars.off_a) begin
                        hold_n   = HOLD_OFF;
                        hold_d_n = in_data;
                    end else if (hold != HOLD_NONE) begin
                        spill_v_n = 1'b1;
                        spill_d_n = in_data;
                    end else begin
                        fwd_v = 1'b1;
                        fwd_d = in_data;
                    end
                end
            end else if (is_on) begin
                on_evt = 1'b1;
            end else if (is_off) begin
                off_evt = 1'b1;
            end else begin
                fwd_v = 1'b1;
                fwd_d = in_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            spill_v   <= 1'b0;
            spill_d   <= '0;
            hold      <= HOLD_NONE;
            hold_d    <= '0;
        end else begin
            out_valid <= fwd_v;
            out_data  <= fwd_d;
            spill_v   <= spill_v_n;
            spill_d   <= spill_d_n;
            hold      <= hold_n;
            hold_d    <= hold_d_n;
        end
    end

    AST_PLAIN_FWD: assert property (@(posedge clk) disable iff (rst)
        (mode.rx == FC_NONE && in_valid && !spill_v)
            |=> (out_valid && out_data == $past(in_data)));  // R1

    AST_BROKEN_FLUSH: assert property (@(posedge clk) disable iff (rst)
        $rose(spill_v) |-> out_valid);  // R4

endmodule

// File: rtl/uart_swfc_tx.sv
module uart_swfc_tx
    import uart_swfc_pkg::*;
#(
    parameter int OCC_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  fc_sel_e           tx_sel,
    input  fc_chars_t         chars,
    input  logic [OCC_W-1:0]  hi_thr,
    input  logic [OCC_W-1:0]  lo_thr,
    input  logic [OCC_W-1:0]  occ,
    input  logic              on_evt,
    input  logic              off_evt,
    input  logic              host_valid,
    input  logic [CHAR_W-1:0] host_data,
    output logic              host_ready,
    output logic              out_valid,
    output logic [CHAR_W-1:0] out_data,
    input  logic              out_ready,
    output logic              pause
);

    ins_e              ins_st;
    logic              ins_off;
    logic              stop_sent;
    logic [CHAR_W-1:0] ins_byte;
    logic              ins_busy;

    assign ins_busy = (ins_st != INS_IDLE);

    always_comb begin
        if (ins_st == INS_SECOND) begin
            ins_byte = ins_off ? chars.off_b : chars.on_b;
        end else if (tx_sel == FC_SETB) begin
            ins_byte = ins_off ? chars.off_b : chars.on_b;
        end else begin
            ins_byte = ins_off ? chars.off_a : chars.on_a;
        end
    end

    always_comb begin
        if (ins_busy) begin
            out_valid  = 1'b1;
            out_data   = ins_byte;
            host_ready = 1'b0;
        end else begin
            out_valid  = host_valid && !pause;
            out_data   = host_data;
            host_ready = out_ready && !pause;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pause <= 1'b0;
        end else if (off_evt) begin
            pause <= 1'b1;
        end else if (on_evt) begin
            pause <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ins_st    <= INS_IDLE;
            ins_off   <= 1'b0;
            stop_sent <= 1'b0;
        end else begin
            unique case (ins_st)
                INS_IDLE: begin
                    if (tx_sel == FC_NONE) begin
                        stop_sent <= 1'b0;
                    end else if (!stop_sent && occ >= hi_thr) begin
                        stop_sent <= 1'b1;
                        ins_off   <= 1'b1;
                        ins_st    <= INS_FIRST;
                    end else if (stop_sent && occ <= lo_thr) begin
                        stop_sent <= 1'b0;
                        ins_off   <= 1'b0;
                        ins_st    <= INS_FIRST;
                    end
                end
                INS_FIRST: begin
                    if (out_ready) begin
                        ins_st <= (tx_sel == FC_BOTH) ? INS_SECOND : INS_IDLE;
                    end
                end
                INS_SECOND: begin
                    if (out_ready) begin
                        ins_st <= INS_IDLE;
                    end
                end
                default: ins_st <= INS_IDLE;
            endcase
        end
    end

    AST_INS_STABLE: assert property (@(posedge clk) disable iff (rst)
        (ins_busy && !out_ready) |=> (out_valid && $stable(out_data)));  // R8

    AST_INS_LOCKS_HOST: assert property (@(posedge clk) disable iff (rst)
        ins_busy |-> !host_ready);  // R8

    AST_PAIR_ORDER: assert property (@(posedge clk) disable iff (rst)
        (ins_st == INS_SECOND) |-> ($past(ins_st) != INS_IDLE));  // R7

    AST_PAUSE_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        (pause && !ins_busy) |-> !(out_valid || host_ready));  // R6

endmodule

// File: rtl/uart_swfc.sv
module uart_swfc
    import uart_swfc_pkg::*;
#(
    parameter int OCC_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr,
    input  logic [3:0]        cfg_mode,
    input  logic              cfg_spc_en,
    input  logic [CHAR_W-1:0] cfg_xon1,
    input  logic [CHAR_W-1:0] cfg_xon2,
    input  logic [CHAR_W-1:0] cfg_xoff1,
    input  logic [CHAR_W-1:0] cfg_xoff2,
    input  logic [OCC_W-1:0]  cfg_hi_thr,
    input  logic [OCC_W-1:0]  cfg_lo_thr,
    input  logic [OCC_W-1:0]  rx_occ,
    input  logic              rx_in_valid,
    input  logic [CHAR_W-1:0] rx_in_data,
    output logic              rx_out_valid,
    output logic [CHAR_W-1:0] rx_out_data,
    input  logic              tx_data_valid,
    input  logic [CHAR_W-1:0] tx_data,
    output logic              tx_data_ready,
    output logic              tx_out_valid,
    output logic [CHAR_W-1:0] tx_out_data,
    input  logic              tx_out_ready,
    output logic              tx_pause,
    output logic              irq_xoff,
    output logic              irq_spc,
    input  logic              irq_clr
);

    fc_mode_t  mode_q;
    logic      spc_en_q;
    fc_chars_t chars;
    logic      on_evt, off_evt, spc_evt;

    assign chars = '{on_a: cfg_xon1, on_b: cfg_xon2, off_a: cfg_xoff1, off_b: cfg_xoff2};

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q   <= '{tx: FC_NONE, rx: FC_NONE};
            spc_en_q <= 1'b0;
        end else if (cfg_wr) begin
            mode_q   <= fc_mode_t'(cfg_mode);
            spc_en_q <= cfg_spc_en;
        end
    end

    uart_swfc_rx u_rx (
        .clk       (clk),
        .rst       (rst),
        .mode      (mode_q),
        .spc_en    (spc_en_q),
        .chars     (chars),
        .in_valid  (rx_in_valid),
        .in_data   (rx_in_data),
        .out_valid (rx_out_valid),
        .out_data  (rx_out_data),
        .on_evt    (on_evt),
        .off_evt   (off_evt),
        .spc_evt   (spc_evt)
    );

    uart_swfc_tx #(.OCC_W(OCC_W)) u_tx (
        .clk        (clk),
        .rst        (rst),
        .tx_sel     (mode_q.tx),
        .chars      (chars),
        .hi_thr     (cfg_hi_thr),
        .lo_thr     (cfg_lo_thr),
        .occ        (rx_occ),
        .on_evt     (on_evt),
        .off_evt    (off_evt),
        .host_valid (tx_data_valid),
        .host_data  (tx_data),
        .host_ready (tx_data_ready),
        .out_valid  (tx_out_valid),
        .out_data   (tx_out_data),
        .out_ready  (tx_out_ready),
        .pause      (tx_pause)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_xoff <= 1'b0;
            irq_spc  <= 1'b0;
        end else begin
            irq_xoff <= off_evt || (irq_xoff && !irq_clr);
            irq_spc  <= spc_evt || (irq_spc && !irq_clr);
        end
    end

    AST_STOP_ACTS: assert property (@(posedge clk) disable iff (rst)
        off_evt |=> (tx_pause && irq_xoff));  // R2

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        (irq_xoff && !irq_clr) |=> irq_xoff);  // R9

    AST_SPC_STICKY: assert property (@(posedge clk) disable iff (rst)
        (irq_spc && !irq_clr) |=> irq_spc);  // R9

    AST_SPC_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_spc) |-> $past(spc_en_q));  // R5

endmodule

// File: tb/uart_swfc_tb.sv
`timescale 1ns/1ps
module uart_swfc_tb;

    localparam int OCC_W = 6;
    localparam logic [7:0] ON_A  = 8'h11;
    localparam logic [7:0] ON_B  = 8'h91;
    localparam logic [7:0] OFF_A = 8'h13;
    localparam logic [7:0] OFF_B = 8'h93;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             cfg_wr = 1'b0;
    logic [3:0]       cfg_mode = '0;
    logic             cfg_spc_en = 1'b0;
    logic [OCC_W-1:0] rx_occ = '0;
    logic             rx_in_valid = 1'b0;
    logic [7:0]       rx_in_data = '0;
    logic             rx_out_valid;
    logic [7:0]       rx_out_data;
    logic             tx_data_valid = 1'b0;
    logic [7:0]       tx_data = 8'h41;
    logic             tx_data_ready;
    logic             tx_out_valid;
    logic [7:0]       tx_out_data;
    logic             tx_out_ready = 1'b1;
    logic             tx_pause, irq_xoff, irq_spc;
    logic             irq_clr = 1'b0;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;
    logic [7:0] rxq[$];
    logic [7:0] txq[$];

    always #2.5 clk = ~clk;

    uart_swfc #(.OCC_W(OCC_W)) u_dut (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_mode(cfg_mode),
        .cfg_spc_en(cfg_spc_en), .cfg_xon1(ON_A), .cfg_xon2(ON_B),
        .cfg_xoff1(OFF_A), .cfg_xoff2(OFF_B), .cfg_hi_thr(6'd8),
        .cfg_lo_thr(6'd2), .rx_occ(rx_occ), .rx_in_valid(rx_in_valid),
        .rx_in_data(rx_in_data), .rx_out_valid(rx_out_valid),
        .rx_out_data(rx_out_data), .tx_data_valid(tx_data_valid),
        .tx_data(tx_data), .tx_data_ready(tx_data_ready),
        .tx_out_valid(tx_out_valid), .tx_out_data(tx_out_data),
        .tx_out_ready(tx_out_ready), .tx_pause(tx_pause),
        .irq_xoff(irq_xoff), .irq_spc(irq_spc), .irq_clr(irq_clr)
    );

    // Monitor: records FIFO writes and serializer handshakes
    always @(negedge clk) begin
        #1;
        if (!rst && rx_out_valid) rxq.push_back(rx_out_data);
        if (!rst && tx_out_valid && tx_out_ready) txq.push_back(tx_out_data);
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic rx_char(input logic [7:0] b);
        @(negedge clk);
        rx_in_valid = 1'b1;
        rx_in_data  = b;
        @(negedge clk);
        rx_in_valid = 1'b0;
        @(negedge clk);
        #2;
    endtask

    task automatic set_mode(input logic [3:0] m, input logic spc);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_mode = m; cfg_spc_en = spc;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic clr_irq();
        @(negedge clk);
        irq_clr = 1'b1;
        @(negedge clk);
        irq_clr = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 pause", tx_pause, 0);
        chk("R1 irq_xoff", irq_xoff, 0);
        chk("R1 irq_spc", irq_spc, 0);
        chk("R1 fifo idle", rx_out_valid, 0);
        rxq.delete();
        rx_char(OFF_A);
        chk("R1 forwarded count", rxq.size(), 1);
        if (rxq.size() > 0) chk("R1 forwarded value", rxq[0], OFF_A);
        chk("R1 no pause", tx_pause, 0);
    endtask

    task automatic t_rx_single();
        set_mode(4'b0010, 1'b0);
        rxq.delete();
        rx_char(OFF_A);
        chk("R2 stop pauses", tx_pause, 1);
        chk("R2 stop flag", irq_xoff, 1);
        rx_char(8'h55);
        chk("R2 other keeps pause", tx_pause, 1);
        rx_char(ON_A);
        chk("R2 resume clears", tx_pause, 0);
        rx_char(OFF_B);
        chk("R2 B char ignored in A mode", tx_pause, 0);
        chk("R2 forwarded count", rxq.size(), 2);
        if (rxq.size() == 2) begin
            chk("R2 data byte", rxq[0], 8'h55);
            chk("R2 B byte forwarded", rxq[1], OFF_B);
        end
        set_mode(4'b0001, 1'b0);
        rxq.delete();
        rx_char(OFF_B);
        chk("R2 stop B pauses", tx_pause, 1);
        rx_char(ON_B);
        chk("R2 resume B clears", tx_pause, 0);
        chk("R2 B chars consumed", rxq.size(), 0);
        clr_irq();
    endtask

    task automatic t_rx_any();
        set_mode(4'b1011, 1'b0);
        rxq.delete();
        rx_char(OFF_B);
        chk("R3 off-B stops", tx_pause, 1);
        rx_char(ON_A);
        chk("R3 on-A resumes", tx_pause, 0);
        rx_char(OFF_A);
        chk("R3 off-A stops", tx_pause, 1);
        rx_char(ON_B);
        chk("R3 on-B resumes", tx_pause, 0);
        chk("R3 all consumed", rxq.size(), 0);
    endtask

    task automatic t_rx_seq();
        set_mode(4'b0011, 1'b0);
        rxq.delete();
        rx_char(OFF_A);
        chk("R4 first byte alone waits", tx_pause, 0);
        rx_char(OFF_B);
        chk("R4 stop pair pauses", tx_pause, 1);
        chk("R4 stop pair consumed", rxq.size(), 0);
        rx_char(ON_A);
        rx_char(8'h42);
        chk("R4 broken pair keeps pause", tx_pause, 1);
        chk("R4 broken pair count", rxq.size(), 2);
        if (rxq.size() == 2) begin
            chk("R4 held byte first", rxq[0], ON_A);
            chk("R4 new byte second", rxq[1], 8'h42);
        end
        rx_char(OFF_A);
        rx_char(ON_A);
        rx_char(ON_B);
        chk("R4 resume pair after broken stop", tx_pause, 0);
        chk("R4 flushed off-A count", rxq.size(), 3);
        if (rxq.size() == 3) chk("R4 flushed off-A", rxq[2], OFF_A);
        clr_irq();
    endtask

    task automatic t_spc();
        set_mode(4'b0010, 1'b1);
        rxq.delete();
        rx_char(OFF_B);
        chk("R5 spc flag A mode", irq_spc, 1);
        chk("R5 no stop flag A mode", irq_xoff, 0);
        chk("R5 forwarded in A mode", rxq.size(), 1);
        clr_irq();
        set_mode(4'b0001, 1'b1);
        rxq.delete();
        rx_char(OFF_B);
        chk("R5 spc flag B mode", irq_spc, 1);
        chk("R5 stop flag B mode", irq_xoff, 1);
        chk("R5 pause B mode", tx_pause, 1);
        chk("R5 consumed in B mode", rxq.size(), 0);
        rx_char(ON_B);
        clr_irq();
        set_mode(4'b0010, 1'b0);
        rxq.delete();
        rx_char(OFF_B);
        chk("R5 disabled no flag", irq_spc, 0);
        chk("R5 disabled forwarded", rxq.size(), 1);
    endtask

    task automatic t_irq();
        set_mode(4'b0010, 1'b0);
        rx_char(OFF_A);
        repeat (5) @(negedge clk);
        chk("R9 flag sticky", irq_xoff, 1);
        clr_irq();
        #1;
        chk("R9 flag cleared", irq_xoff, 0);
        @(negedge clk);
        rx_in_valid = 1'b1; rx_in_data = OFF_A; irq_clr = 1'b1;
        @(negedge clk);
        rx_in_valid = 1'b0; irq_clr = 1'b0;
        #1;
        chk("R9 set wins over clear", irq_xoff, 1);
        rx_char(ON_A);
        clr_irq();
    endtask

    task automatic t_pause_tx();
        set_mode(4'b0010, 1'b0);
        rx_char(OFF_A);
        txq.delete();
        @(negedge clk);
        tx_data_valid = 1'b1;
        #1;
        chk("R6 host not taken", tx_data_ready, 0);
        chk("R6 nothing offered", tx_out_valid, 0);
        repeat (3) @(negedge clk);
        #2;
        chk("R6 no sends while paused", txq.size(), 0);
        rx_char(ON_A);
        chk("R6 sends after resume", (txq.size() > 0), 1);
        if (txq.size() > 0) chk("R6 host byte", txq[0], 8'h41);
        @(negedge clk);
        tx_data_valid = 1'b0;
        clr_irq();
    endtask

    task automatic t_thresh();
        set_mode(4'b1100, 1'b0);
        @(negedge clk);
        tx_out_ready = 1'b0;
        tx_data_valid = 1'b1;
        rx_occ = 6'd8;
        @(negedge clk);
        #1;
        chk("R8 insert offered", tx_out_valid, 1);
        chk("R8 insert preempts host", tx_out_data, OFF_A);
        chk("R8 host locked", tx_data_ready, 0);
        repeat (2) @(negedge clk);
        #1;
        chk("R8 insert held", tx_out_data, OFF_A);
        tx_data_valid = 1'b0;
        txq.delete();
        tx_out_ready = 1'b1;
        repeat (4) @(negedge clk);
        #2;
        chk("R7 stop pair count", txq.size(), 2);
        if (txq.size() == 2) begin
            chk("R7 stop pair first", txq[0], OFF_A);
            chk("R7 stop pair second", txq[1], OFF_B);
        end
        txq.delete();
        rx_occ = 6'd5;
        repeat (3) @(negedge clk);
        #2;
        chk("R7 hysteresis quiet", txq.size(), 0);
        rx_occ = 6'd2;
        repeat (4) @(negedge clk);
        #2;
        chk("R7 resume pair count", txq.size(), 2);
        if (txq.size() == 2) begin
            chk("R7 resume pair first", txq[0], ON_A);
            chk("R7 resume pair second", txq[1], ON_B);
        end
        set_mode(4'b1000, 1'b0);
        txq.delete();
        rx_occ = 6'd8;
        repeat (4) @(negedge clk);
        #2;
        chk("R7 single A count", txq.size(), 1);
        if (txq.size() == 1) chk("R7 single A stop", txq[0], OFF_A);
        set_mode(4'b0100, 1'b0);
        txq.delete();
        rx_occ = 6'd2;
        repeat (4) @(negedge clk);
        #2;
        chk("R7 single B count", txq.size(), 1);
        if (txq.size() == 1) chk("R7 single B resume", txq[0], ON_B);
        set_mode(4'b0000, 1'b0);
        txq.delete();
        rx_occ = 6'd9;
        repeat (4) @(negedge clk);
        #2;
        chk("R7 tx off sends nothing", txq.size(), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        t_reset();
        t_rx_single();
        t_rx_any();
        t_rx_seq();
        t_spc();
        t_irq();
        t_pause_tx();
        t_thresh();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule